// File: doc/BRIEF.md
# EX-Stage Operand Forwarding Unit

This block sits beside the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where the operand value comes from. There are three sources. The first is the value read from the register file during decode. The second is the result held by the register between execute and memory, which is the newest result. The third is the write-back value held by the register between memory and write-back, which is one instruction older.

The unit compares the two source register numbers of the instruction now in execute with the destination numbers and write-enable flags of the two older instructions ahead of it. From that comparison it forms a 2-bit select for each operand. When the parameter `HAS_MUX` is 1, the unit also contains the two 3-to-1 operand multiplexers, and it drives the chosen data directly. The whole path is combinational, so each select and each operand is valid in the same cycle as the inputs that produce it.

Top module: `fwd_unit`

## Requirements
- R1: When neither older instruction qualifies as a source for an operand, that operand's select is 2'b00 (register file). The value 2'b11 never appears on a select.
- R2: An operand's select is 2'b10 when the execute/memory write flag is 1, the execute/memory destination is nonzero, and that destination equals the operand's register number.
- R3: An operand's select is 2'b01 when the memory/write-back write flag is 1, its destination is nonzero, it equals the operand's register number, and the R2 condition for that operand is false.
- R4: When both older instructions qualify for the same operand, the select is 2'b10, so the newer result wins.
- R5: Register number 0 never causes forwarding, whatever the write flags are. An operand whose register number is 0 always selects 2'b00.
- R6: A matching destination whose write flag is 0 has no effect on the select.
- R7: Select A depends only on the first source register number (rs). Select B depends only on the second source register number (rt). The two are evaluated independently.
- R8: With HAS_MUX=1, each operand output equals the register-file data for select 2'b00, the execute/memory result for 2'b10, and the write-back data for 2'b01.
- R9: Selects and operands follow input changes within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_ex_rs | input | REG_W | First source register number of the instruction in execute |
| id_ex_rt | input | REG_W | Second source register number of the instruction in execute |
| ex_mem_rd | input | REG_W | Destination number held in the execute/memory register |
| ex_mem_wr | input | 1 | Write flag held in the execute/memory register |
| mem_wb_rd | input | REG_W | Destination number held in the memory/write-back register |
| mem_wb_wr | input | 1 | Write flag held in the memory/write-back register |
| rf_a | input | DATA_W | Register-file value for operand A |
| rf_b | input | DATA_W | Register-file value for operand B |
| ex_mem_result | input | DATA_W | ALU result held in the execute/memory register |
| mem_wb_data | input | DATA_W | Write-back value held in the memory/write-back register |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DATA_W | Chosen operand A |
| opnd_b | output | DATA_W | Chosen operand B |

## Verification
Every result of this block is due in the same cycle as its inputs, which is zero cycles of latency. The bench changes the inputs on the falling clock edge. One nanosecond later, still inside the same cycle, it compares both selects and both operands against a behavioural model. The model is checked on every clock, so a registered or delayed output would mismatch immediately. Register numbers are drawn from a small range so that matches, double matches and register 0 appear often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;
  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/fwd_match.sv
// One source/operand comparison: the source writes, its destination is not register 0, and it matches the operand.
module fwd_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic             src_wr,
  input  logic [REG_W-1:0] src_rd,
  input  logic [REG_W-1:0] opnd_reg,
  output logic             hit
);
  logic rd_nonzero;
  assign rd_nonzero = |src_rd;
  assign hit = src_wr & rd_nonzero & (src_rd == opnd_reg);
endmodule

// File: rtl/fwd_select.sv
// Priority select for one operand: the newer source is tested first.
module fwd_select
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] opnd_reg,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wr,
  output fwd_sel_e         sel
);
  logic ex_hit;
  logic wb_hit;

  fwd_match #(.REG_W(REG_W)) u_ex_match (
    .src_wr(ex_wr), .src_rd(ex_rd), .opnd_reg(opnd_reg), .hit(ex_hit)
  );
  fwd_match #(.REG_W(REG_W)) u_wb_match (
    .src_wr(wb_wr), .src_rd(wb_rd), .opnd_reg(opnd_reg), .hit(wb_hit)
  );

  always_comb begin
    if (ex_hit)      sel = SEL_EXMEM;
    else if (wb_hit) sel = SEL_MEMWB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/fwd_opnd_mux.sv
// 3-to-1 operand multiplexer driven by a forwarding select.
module fwd_opnd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] ex_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SEL_EXMEM: opnd = ex_val;
      SEL_MEMWB: opnd = wb_val;
      default:   opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
// EX-stage forwarding unit: two selects, with optional operand multiplexers.
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned DATA_W  = 32,
  parameter bit          HAS_MUX = 1'b1
) (
  input  logic [REG_W-1:0]  id_ex_rs,
  input  logic [REG_W-1:0]  id_ex_rt,
  input  logic [REG_W-1:0]  ex_mem_rd,
  input  logic              ex_mem_wr,
  input  logic [REG_W-1:0]  mem_wb_rd,
  input  logic              mem_wb_wr,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] ex_mem_result,
  input  logic [DATA_W-1:0] mem_wb_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  logic [REG_W-1:0]  opnd_reg [NUM_OPND];
  logic [DATA_W-1:0] rf_val   [NUM_OPND];
  logic [DATA_W-1:0] opnd_val [NUM_OPND];
  fwd_sel_e          sel      [NUM_OPND];

  assign opnd_reg[0] = id_ex_rs;
  assign opnd_reg[1] = id_ex_rt;
  assign rf_val[0]   = rf_a;
  assign rf_val[1]   = rf_b;

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    fwd_select #(.REG_W(REG_W)) u_sel (
      .opnd_reg(opnd_reg[i]),
      .ex_rd   (ex_mem_rd),
      .ex_wr   (ex_mem_wr),
      .wb_rd   (mem_wb_rd),
      .wb_wr   (mem_wb_wr),
      .sel     (sel[i])
    );
    if (HAS_MUX) begin : g_mux
      fwd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
        .sel   (sel[i]),
        .rf_val(rf_val[i]),
        .ex_val(ex_mem_result),
        .wb_val(mem_wb_data),
        .opnd  (opnd_val[i])
      );
    end else begin : g_nomux
      assign opnd_val[i] = rf_val[i];
    end
  end

  assign sel_a  = sel[0];
  assign sel_b  = sel[1];
  assign opnd_a = opnd_val[0];
  assign opnd_b = opnd_val[1];
endmodule

// File: rtl/fwd_unit_checker.sv
// Port-level checks for the forwarding unit, attached by bind.
module fwd_unit_checker #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned DATA_W  = 32,
  parameter bit          HAS_MUX = 1'b1
) (
  input logic [REG_W-1:0]  id_ex_rs,
  input logic [REG_W-1:0]  id_ex_rt,
  input logic [REG_W-1:0]  ex_mem_rd,
  input logic              ex_mem_wr,
  input logic [REG_W-1:0]  mem_wb_rd,
  input logic              mem_wb_wr,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic [DATA_W-1:0] ex_mem_result,
  input logic [DATA_W-1:0] mem_wb_data,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);
  always_comb begin
    assert_sel_legal_R1: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select took the illegal code 11");
    assert_zero_reg_R5: assert (!((sel_a == 2'b10 && ex_mem_rd == '0) ||
                                  (sel_a == 2'b01 && mem_wb_rd == '0) ||
                                  (sel_b == 2'b10 && ex_mem_rd == '0) ||
                                  (sel_b == 2'b01 && mem_wb_rd == '0)))
      else $error("register 0 used as a forwarding source");
    assert_no_wr_R6: assert (!((sel_a == 2'b10 || sel_b == 2'b10) && !ex_mem_wr) &&
                             !((sel_a == 2'b01 || sel_b == 2'b01) && !mem_wb_wr))
      else $error("forward from a source whose write flag is low");
    assert_newer_wins_R4: assert (!(ex_mem_wr && ex_mem_rd != '0 &&
                                    ex_mem_rd == id_ex_rs && sel_a != 2'b10) &&
                                  !(ex_mem_wr && ex_mem_rd != '0 &&
                                    ex_mem_rd == id_ex_rt && sel_b != 2'b10))
      else $error("newer result not selected");
    assert_reg_match_R7: assert (!(sel_a == 2'b10 && ex_mem_rd != id_ex_rs) &&
                                 !(sel_b == 2'b10 && ex_mem_rd != id_ex_rt) &&
                                 !(sel_a == 2'b01 && mem_wb_rd != id_ex_rs) &&
                                 !(sel_b == 2'b01 && mem_wb_rd != id_ex_rt))
      else $error("select does not match its own operand register");
    if (HAS_MUX) begin
      assert_mux_data_R8: assert (
        (sel_a == 2'b00 ? opnd_a == rf_a :
         sel_a == 2'b10 ? opnd_a == ex_mem_result : opnd_a == mem_wb_data) &&
        (sel_b == 2'b00 ? opnd_b == rf_b :
         sel_b == 2'b10 ? opnd_b == ex_mem_result : opnd_b == mem_wb_data))
        else $error("operand data does not follow its select");
    end
  end
endmodule

bind fwd_unit fwd_unit_checker #(
  .REG_W(REG_W), .DATA_W(DATA_W), .HAS_MUX(HAS_MUX)
) u_fwd_chk (
  .id_ex_rs(id_ex_rs), .id_ex_rt(id_ex_rt),
  .ex_mem_rd(ex_mem_rd), .ex_mem_wr(ex_mem_wr),
  .mem_wb_rd(mem_wb_rd), .mem_wb_wr(mem_wb_wr),
  .rf_a(rf_a), .rf_b(rf_b),
  .ex_mem_result(ex_mem_result), .mem_wb_data(mem_wb_data),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [REG_W-1:0]  id_ex_rs, id_ex_rt, ex_mem_rd, mem_wb_rd;
  logic              ex_mem_wr, mem_wb_wr;
  logic [DATA_W-1:0] rf_a, rf_b, ex_mem_result, mem_wb_data;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W), .HAS_MUX(1'b1)) uut (
    .id_ex_rs(id_ex_rs), .id_ex_rt(id_ex_rt),
    .ex_mem_rd(ex_mem_rd), .ex_mem_wr(ex_mem_wr),
    .mem_wb_rd(mem_wb_rd), .mem_wb_wr(mem_wb_wr),
    .rf_a(rf_a), .rf_b(rf_b),
    .ex_mem_result(ex_mem_result), .mem_wb_data(mem_wb_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Behavioural model: a source counts only if it writes and targets a nonzero, matching register.
  function automatic bit src_counts(int wr, int rd, int reg_no);
    return (wr != 0) && (rd != 0) && (rd == reg_no);
  endfunction

  function automatic int model_sel(int reg_no);
    if (src_counts(ex_mem_wr, ex_mem_rd, reg_no)) return 2;
    if (src_counts(mem_wb_wr, mem_wb_rd, reg_no)) return 1;
    return 0;
  endfunction

  // Requirement tag that explains an expected select.
  function automatic string sel_tag(int reg_no);
    bit e = src_counts(ex_mem_wr, ex_mem_rd, reg_no);
    bit w = src_counts(mem_wb_wr, mem_wb_rd, reg_no);
    if (e && w) return "R4";
    if (e) return "R2";
    if (w) return "R3";
    if (reg_no == 0) return "R5";
    if ((ex_mem_rd == reg_no && !ex_mem_wr) || (mem_wb_rd == reg_no && !mem_wb_wr)) return "R6";
    return "R1";
  endfunction

  task automatic check_val(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare all outputs in the same cycle as the stimulus (R9).
  task automatic compare_all();
    int ea = model_sel(id_ex_rs);
    int eb = model_sel(id_ex_rt);
    logic [DATA_W-1:0] da = (ea == 2) ? ex_mem_result : (ea == 1) ? mem_wb_data : rf_a;
    logic [DATA_W-1:0] db = (eb == 2) ? ex_mem_result : (eb == 1) ? mem_wb_data : rf_b;
    check_val({sel_tag(id_ex_rs), "/R7/R9"}, "sel_a", DATA_W'(sel_a), DATA_W'(ea));
    check_val({sel_tag(id_ex_rt), "/R7/R9"}, "sel_b", DATA_W'(sel_b), DATA_W'(eb));
    check_val("R8", "opnd_a", opnd_a, da);
    check_val("R8", "opnd_b", opnd_b, db);
  endtask

  task automatic drive(int rs, int rt, int erd, int ewr, int wrd, int wwr);
    @(negedge clk);
    id_ex_rs  = REG_W'(rs);
    id_ex_rt  = REG_W'(rt);
    ex_mem_rd = REG_W'(erd);
    ex_mem_wr = ewr[0];
    mem_wb_rd = REG_W'(wrd);
    mem_wb_wr = wwr[0];
    rf_a = $urandom; rf_b = $urandom;
    ex_mem_result = $urandom; mem_wb_data = $urandom;
    #1;
    compare_all();
  endtask

  initial begin
    id_ex_rs = '0; id_ex_rt = '0; ex_mem_rd = '0; mem_wb_rd = '0;
    ex_mem_wr = 1'b0; mem_wb_wr = 1'b0;
    rf_a = 32'h1111_0000; rf_b = 32'h2222_0000;
    ex_mem_result = 32'h3333_0000; mem_wb_data = 32'h4444_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // Reset-state pattern: all inputs idle selects the register file (R1).
    #1 compare_all();
    drive(3, 4, 0, 0, 0, 0);     // R1: nothing qualifies
    drive(2, 5, 2, 1, 0, 0);     // R2: forward A from execute/memory
    drive(6, 2, 2, 1, 0, 0);     // R2/R7: forward B only
    drive(2, 7, 0, 0, 2, 1);     // R3: forward A from write-back
    drive(1, 1, 1, 1, 1, 1);     // R4: both match, newer wins on both operands
    drive(0, 0, 0, 1, 0, 1);     // R5: register 0 never forwards
    drive(0, 9, 0, 1, 9, 1);     // R5 on A, R3 on B
    drive(8, 8, 8, 0, 8, 0);     // R6: matches with write flags low
    drive(8, 8, 8, 0, 8, 1);     // R6 then R3: low flag on newer lets older forward
    drive(4, 5, 4, 1, 5, 1);     // R7: A from newer, B from older
    drive(31, 31, 31, 1, 31, 1); // R4 at top register number
    // Random patterns over a small register range so collisions are frequent.
    for (int n = 0; n < 3000; n++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1));
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule